// File: doc/BRIEF.md
# Processor Debug Halt Controller

This block sits beside a small CPU core and gives a host a word-addressed AXI4-Lite register window for run control and register inspection. It holds the core's enable (run) bit and a break-pending flag. When the core signals that it has executed its software breakpoint instruction, the controller stops the core, latches break pending, and sends the host a one-cycle interrupt pulse.

While the core is halted, the host can read and write the core's general registers. Register slot 0 stands for the program counter, not for the hardwired zero register. The host can reach the coprocessor-0 registers at any time. Both register sets are reached through an indexed port into the core: a strobe, a write flag, an address-space code and a 5-bit index, with read data returned in the same cycle. An 8-bit LED register is also provided.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset, `core_run`, `irq`, `led`, `s_bvalid` and `s_rvalid` are all 0, and the control word reads 0.
- R2: Offset 0x000 is the control word. Bit 0 reads the run bit, bit 1 reads break pending, and all higher bits read 0.
- R3: A write to 0x000 loads the run bit from data bit 0. Writing data bit 1 as 1 clears break pending, and writing it as 0 leaves break pending unchanged. Byte strobes are not used for this register.
- R4: If `core_brk` is high in a cycle where the run bit is 1, then after that clock edge the run bit is 0 and break pending is 1. This takes priority over a host write to 0x000 in the same cycle.
- R5: `irq` is high for exactly one cycle, in the first cycle that break pending reads 1. A breakpoint that arrives while break pending is already set produces no pulse.
- R6: `core_brk` has no effect while the run bit is 0.
- R7: Offset 0x004 holds an 8-bit LED value, driven on `led`. Data bits 7:0 are written only when strobe bit 0 is set. Bits 31:8 read 0.
- R8: Offsets 0x008–0x07C, 0x180 and above, and any address with a bit above bit 8 set, read 0. Writes to them have no effect.
- R9: While the run bit is 0, offset 0x080 + 4·n (n = 0..31) reaches core register n. For n = 0 the access uses space code 0 (program counter). For n ≥ 1 it uses space code 1 (general register), with `dbg_idx` = n.
- R10: While the run bit is 1, reads of 0x080–0x0FC return 0, and writes there issue no core access.
- R11: Offset 0x100 + 4·n reaches coprocessor-0 register n with space code 2, whatever the run bit is.
- R12: Every write and read completes with an OKAY (0) response. `s_bvalid` stays high, and `s_rdata` stays stable, until the host accepts the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response accepted |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data accepted |
| core_brk | input | 1 | Core executed its breakpoint instruction (one cycle) |
| core_run | output | 1 | Run bit; the core advances only while this is high |
| irq | output | 1 | Breakpoint interrupt pulse |
| led | output | 8 | LED register value |
| dbg_req | output | 1 | Indexed register access strobe |
| dbg_we | output | 1 | Access is a write |
| dbg_space | output | 2 | 0 PC, 1 general register, 2 coprocessor-0, 3 idle |
| dbg_idx | output | 5 | Register index |
| dbg_wdata | output | 32 | Register write data |
| dbg_rdata | input | 32 | Register read data, valid in the same cycle |

## Verification
A table of writes and read-backs covers each region of the map: the PC slot, the top and an inner general register, the first and last coprocessor-0 registers, the LED byte under full and partial strobes, and unused offsets both inside and beyond the decoded range. This separates correct decoding from aliasing. The PC check tells a true program-counter alias apart from plain pass-through to general register 0. Directed sequences then toggle run and fire breakpoints in three conditions: while halted, while running with nothing pending, and while running with break pending still set. These show whether the halt, the edge-only interrupt and the clear-on-one behaviour each act alone. Accesses to the general window while running confirm that reads return zero and that writes never reach the core.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;

    localparam int DATA_W  = 32;
    localparam int STRB_W  = DATA_W / 8;
    localparam int WORD_W  = 7;
    localparam int IDX_W   = 5;
    localparam int LED_W   = 8;
    localparam int RUN_BIT = 0;
    localparam int BRK_BIT = 1;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [2:0] {
        RG_CTRL,
        RG_LED,
        RG_GPR,
        RG_COP0,
        RG_NONE
    } region_e;

    typedef enum logic [1:0] {
        SP_PC   = 2'd0,
        SP_GPR  = 2'd1,
        SP_COP0 = 2'd2,
        SP_IDLE = 2'd3
    } space_e;

    typedef struct packed {
        logic               wr;
        logic               rd;
        logic               far;
        logic [WORD_W-1:0]  word;
        logic [DATA_W-1:0]  wdata;
        logic [STRB_W-1:0]  strb;
    } acc_t;

    function automatic region_e region_of(input logic [WORD_W-1:0] word,
                                          input logic far);
        region_e r;
        if (far)                      r = RG_NONE;
        else if (word == 7'd0)        r = RG_CTRL;
        else if (word == 7'd1)        r = RG_LED;
        else if (word[6:5] == 2'b01)  r = RG_GPR;
        else if (word[6:5] == 2'b10)  r = RG_COP0;
        else                          r = RG_NONE;
        return r;
    endfunction

    function automatic space_e space_of(input region_e r,
                                        input logic [IDX_W-1:0] idx);
        space_e s;
        case (r)
            RG_GPR:  s = (idx == '0) ? SP_PC : SP_GPR;
            RG_COP0: s = SP_COP0;
            default: s = SP_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dbgc_axil_port.sv
module dbgc_axil_port
    import dbgc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    s_awaddr,
    input  logic                 s_awvalid,
    output logic                 s_awready,
    input  logic [DATA_W-1:0]    s_wdata,
    input  logic [STRB_W-1:0]    s_wstrb,
    input  logic                 s_wvalid,
    output logic                 s_wready,
    output logic [1:0]           s_bresp,
    output logic                 s_bvalid,
    input  logic                 s_bready,
    input  logic [ADDR_W-1:0]    s_araddr,
    input  logic                 s_arvalid,
    output logic                 s_arready,
    output logic [DATA_W-1:0]    s_rdata,
    output logic [1:0]           s_rresp,
    output logic                 s_rvalid,
    input  logic                 s_rready,
    output acc_t                 acc,
    input  logic [DATA_W-1:0]    rd_val
);

    localparam int LO_B = 2;
    localparam int HI_B = LO_B + WORD_W;

    logic wr_go, rd_go;
    logic aw_far, ar_far;

    generate
        if (ADDR_W > HI_B) begin : g_far
            assign aw_far = |s_awaddr[ADDR_W-1:HI_B];
            assign ar_far = |s_araddr[ADDR_W-1:HI_B];
        end else begin : g_near
            assign aw_far = 1'b0;
            assign ar_far = 1'b0;
        end
    endgenerate

    // a write needs address and data together and a free response slot;
    // it wins over a read offered in the same cycle
    assign wr_go     = s_awvalid && s_wvalid && !s_bvalid;
    assign rd_go     = s_arvalid && !s_rvalid && !wr_go;
    assign s_awready = wr_go;
    assign s_wready  = wr_go;
    assign s_arready = rd_go;

    always_comb begin
        acc.wr    = wr_go;
        acc.rd    = rd_go;
        acc.far   = wr_go ? aw_far : ar_far;
        acc.word  = wr_go ? s_awaddr[HI_B-1:LO_B] : s_araddr[HI_B-1:LO_B];
        acc.wdata = s_wdata;
        acc.strb  = s_wstrb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_bvalid <= 1'b0;
        end else if (wr_go) begin
            s_bvalid <= 1'b1;
        end else if (s_bready) begin
            s_bvalid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_rvalid <= 1'b0;
            s_rdata  <= '0;
        end else if (rd_go) begin
            s_rvalid <= 1'b1;
            s_rdata  <= rd_val;
        end else if (s_rready) begin
            s_rvalid <= 1'b0;
        end
    end

    assign s_bresp = RESP_OKAY;
    assign s_rresp = RESP_OKAY;

    p_bvalid_hold_r12: assert property (@(posedge clk) disable iff (rst)
        s_bvalid && !s_bready |=> s_bvalid);

    p_rdata_stable_r12: assert property (@(posedge clk) disable iff (rst)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));

    p_single_access_r12: assert property (@(posedge clk) disable iff (rst)
        !(s_awready && s_arready));

endmodule

// File: rtl/dbgc_run_ctl.sv
module dbgc_run_ctl
    import dbgc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  region_e           rg,
    input  logic              core_brk,
    output logic              run,
    output logic              brk_pend,
    output logic              irq,
    output logic [LED_W-1:0]  led
);

    logic ctrl_wr, led_wr, brk_take;
    logic run_n, pend_n;

    assign ctrl_wr  = acc.wr && (rg == RG_CTRL);
    assign led_wr   = acc.wr && (rg == RG_LED) && acc.strb[0];
    assign brk_take = core_brk && run;

    always_comb begin
        run_n  = run;
        pend_n = brk_pend;
        if (ctrl_wr) begin
            run_n = acc.wdata[RUN_BIT];
            if (acc.wdata[BRK_BIT]) pend_n = 1'b0;
        end
        if (brk_take) begin
            run_n  = 1'b0;
            pend_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            brk_pend <= 1'b0;
            irq      <= 1'b0;
        end else begin
            run      <= run_n;
            brk_pend <= pend_n;
            irq      <= pend_n && !brk_pend;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            led <= '0;
        end else if (led_wr) begin
            led <= acc.wdata[LED_W-1:0];
        end
    end

    p_brk_halts_r4: assert property (@(posedge clk) disable iff (rst)
        core_brk && run |=> !run && brk_pend);

    p_brk_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        core_brk && !run && !ctrl_wr |=> !run && $stable(brk_pend));

    p_irq_single_r5: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    p_irq_on_edge_r5: assert property (@(posedge clk) disable iff (rst)
        irq |-> brk_pend && !$past(brk_pend));

    p_led_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !led_wr |=> $stable(led));

endmodule

// File: rtl/dbgc_core_port.sv
module dbgc_core_port
    import dbgc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  acc_t               acc,
    input  region_e            rg,
    input  logic               run,
    output logic               dbg_req,
    output logic               dbg_we,
    output logic [1:0]         dbg_space,
    output logic [IDX_W-1:0]   dbg_idx,
    output logic [DATA_W-1:0]  dbg_wdata,
    input  logic [DATA_W-1:0]  dbg_rdata,
    output logic [DATA_W-1:0]  core_val
);

    logic   open_win;
    logic   hit;
    space_e sp;

    // general window only while halted, coprocessor window always
    assign open_win = ((rg == RG_GPR) && !run) || (rg == RG_COP0);
    assign hit      = open_win && (acc.wr || acc.rd);
    assign sp       = hit ? space_of(rg, acc.word[IDX_W-1:0]) : SP_IDLE;

    assign dbg_req   = hit;
    assign dbg_we    = hit && acc.wr;
    assign dbg_space = sp;
    assign dbg_idx   = acc.word[IDX_W-1:0];
    assign dbg_wdata = acc.wdata;
    assign core_val  = open_win ? dbg_rdata : '0;

    p_gpr_gated_r10: assert property (@(posedge clk) disable iff (rst)
        dbg_req && (dbg_space != SP_COP0) |-> !run);

    p_pc_alias_r9: assert property (@(posedge clk) disable iff (rst)
        dbg_req && (dbg_space == SP_PC) |-> (dbg_idx == '0));

    p_idle_space_r9: assert property (@(posedge clk) disable iff (rst)
        !dbg_req |-> (dbg_space == SP_IDLE) && !dbg_we);

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbgc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  s_awaddr,
    input  logic               s_awvalid,
    output logic               s_awready,
    input  logic [31:0]        s_wdata,
    input  logic [3:0]         s_wstrb,
    input  logic               s_wvalid,
    output logic               s_wready,
    output logic [1:0]         s_bresp,
    output logic               s_bvalid,
    input  logic               s_bready,
    input  logic [ADDR_W-1:0]  s_araddr,
    input  logic               s_arvalid,
    output logic               s_arready,
    output logic [31:0]        s_rdata,
    output logic [1:0]         s_rresp,
    output logic               s_rvalid,
    input  logic               s_rready,
    input  logic               core_brk,
    output logic               core_run,
    output logic               irq,
    output logic [7:0]         led,
    output logic               dbg_req,
    output logic               dbg_we,
    output logic [1:0]         dbg_space,
    output logic [4:0]         dbg_idx,
    output logic [31:0]        dbg_wdata,
    input  logic [31:0]        dbg_rdata
);

    acc_t              acc;
    region_e           rg;
    logic              brk_pend;
    logic [DATA_W-1:0] core_val;
    logic [DATA_W-1:0] rd_val;

    assign rg = region_of(acc.word, acc.far);

    dbgc_axil_port #(.ADDR_W(ADDR_W)) u_port (
        .clk       (clk),
        .rst       (rst),
        .s_awaddr  (s_awaddr),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_wdata   (s_wdata),
        .s_wstrb   (s_wstrb),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_bresp   (s_bresp),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_araddr  (s_araddr),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .acc       (acc),
        .rd_val    (rd_val)
    );

    dbgc_run_ctl u_run (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .rg       (rg),
        .core_brk (core_brk),
        .run      (core_run),
        .brk_pend (brk_pend),
        .irq      (irq),
        .led      (led)
    );

    dbgc_core_port u_core (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .rg        (rg),
        .run       (core_run),
        .dbg_req   (dbg_req),
        .dbg_we    (dbg_we),
        .dbg_space (dbg_space),
        .dbg_idx   (dbg_idx),
        .dbg_wdata (dbg_wdata),
        .dbg_rdata (dbg_rdata),
        .core_val  (core_val)
    );

    always_comb begin
        rd_val = '0;
        case (rg)
            RG_CTRL: begin
                rd_val[RUN_BIT] = core_run;
                rd_val[BRK_BIT] = brk_pend;
            end
            RG_LED:  rd_val[LED_W-1:0] = led;
            RG_GPR,
            RG_COP0: rd_val = core_val;
            default: rd_val = '0;
        endcase
    end

    p_none_reads_zero_r8: assert property (@(posedge clk) disable iff (rst)
        s_arready && (rg == RG_NONE) |=> s_rvalid && (s_rdata == '0));

    p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        s_arready && (rg == RG_CTRL) |=> (s_rdata[DATA_W-1:2] == '0));

endmodule

// File: tb/sim_dbg_halt_ctrl.sv
module sim_dbg_halt_ctrl;

    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [AW-1:0] awaddr = '0, araddr = '0;
    logic awvalid = 0, wvalid = 0, arvalid = 0;
    logic [31:0] wdata = '0;
    logic [3:0] wstrb = '0;
    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0] bresp, rresp;
    logic [31:0] rdata;
    logic core_brk = 0;
    logic core_run, irq;
    logic [7:0] led;
    logic dbg_req, dbg_we;
    logic [1:0] dbg_space;
    logic [4:0] dbg_idx;
    logic [31:0] dbg_wdata, dbg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    dbg_halt_ctrl #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(1'b1),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(1'b1),
        .core_brk(core_brk), .core_run(core_run), .irq(irq), .led(led),
        .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_space(dbg_space),
        .dbg_idx(dbg_idx), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
    );

    // core register model: space 0 PC, 1 general, 2 coprocessor-0
    logic [31:0] pc_m;
    logic [31:0] gpr_m [32];
    logic [31:0] cop_m [32];
    int core_wr_cnt = 0;

    always_comb begin
        case (dbg_space)
            2'd0:    dbg_rdata = pc_m;
            2'd1:    dbg_rdata = gpr_m[dbg_idx];
            2'd2:    dbg_rdata = cop_m[dbg_idx];
            default: dbg_rdata = 32'hEEEE_EEEE;
        endcase
    end

    always @(posedge clk) begin
        if (dbg_req && dbg_we) begin
            core_wr_cnt <= core_wr_cnt + 1;
            case (dbg_space)
                2'd0: pc_m <= dbg_wdata;
                2'd1: gpr_m[dbg_idx] <= dbg_wdata;
                2'd2: cop_m[dbg_idx] <= dbg_wdata;
                default: ;
            endcase
        end
    end

    initial begin
        pc_m = '0;
        for (int i = 0; i < 32; i++) begin
            gpr_m[i] = '0;
            cop_m[i] = '0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic axi_wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
        while (!awready) @(negedge clk);
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        chk("R12 bvalid", {31'b0, bvalid}, 32'd1);
        chk("R12 bresp", {30'b0, bresp}, 32'd0);
    endtask

    task automatic axi_rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 0;
        d = rdata;
        if (!rvalid || rresp != 2'b00) begin
            checks++; errors++;
            $display("FAIL R12 rvalid=%b rresp=%b expected 1/00", rvalid, rresp);
        end
    endtask

    task automatic brk_pulse();
        @(negedge clk); core_brk = 1;
        @(negedge clk); core_brk = 0;
    endtask

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [3:0]  strb;
        logic [31:0] exp;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h080, 32'h0000_1000, 4'hF, 32'h0,         "R9"},  // PC slot
        '{1'b0, 12'h080, 32'h0,         4'h0, 32'h0000_1000, "R9"},
        '{1'b1, 12'h0FC, 32'hA5A5_0001, 4'hF, 32'h0,         "R9"},
        '{1'b0, 12'h0FC, 32'h0,         4'h0, 32'hA5A5_0001, "R9"},
        '{1'b1, 12'h084, 32'h1111_2222, 4'h1, 32'h0,         "R9"},
        '{1'b0, 12'h084, 32'h0,         4'h0, 32'h1111_2222, "R9"},
        '{1'b1, 12'h100, 32'hCAFE_0000, 4'hF, 32'h0,         "R11"},
        '{1'b0, 12'h100, 32'h0,         4'h0, 32'hCAFE_0000, "R11"},
        '{1'b1, 12'h17C, 32'h1234_5678, 4'hF, 32'h0,         "R11"},
        '{1'b0, 12'h17C, 32'h0,         4'h0, 32'h1234_5678, "R11"},
        '{1'b1, 12'h004, 32'hFFFF_FF3C, 4'h1, 32'h0,         "R7"},
        '{1'b0, 12'h004, 32'h0,         4'h0, 32'h0000_003C, "R7"},
        '{1'b1, 12'h004, 32'h0000_0099, 4'hE, 32'h0,         "R7"},  // strobe 0 off
        '{1'b0, 12'h004, 32'h0,         4'h0, 32'h0000_003C, "R7"},
        '{1'b1, 12'h040, 32'hDEAD_BEEF, 4'hF, 32'h0,         "R8"},
        '{1'b0, 12'h040, 32'h0,         4'h0, 32'h0,         "R8"},
        '{1'b1, 12'h180, 32'hDEAD_BEEF, 4'hF, 32'h0,         "R8"},
        '{1'b0, 12'h180, 32'h0,         4'h0, 32'h0,         "R8"},
        '{1'b0, 12'h880, 32'h0,         4'h0, 32'h0,         "R8"},  // high bit set
        '{1'b0, 12'h000, 32'h0,         4'h0, 32'h0,         "R2"}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rv;
        int wr_before;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 core_run", {31'b0, core_run}, 32'd0);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 led", {24'b0, led}, 32'd0);
        chk("R1 bvalid/rvalid", {30'b0, bvalid, rvalid}, 32'd0);
        axi_rd(12'h000, rv); chk("R1 ctrl", rv, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) axi_wr(VECS[i].addr, VECS[i].data, VECS[i].strb);
            else begin
                axi_rd(VECS[i].addr, rv);
                chk($sformatf("%s vec%0d", VECS[i].tag, i), rv, VECS[i].exp);
            end
        end
        chk("R9 pc alias not gpr0", gpr_m[0], 32'd0);
        chk("R9 pc model", pc_m, 32'h0000_1000);
        chk("R7 led pin", {24'b0, led}, 32'h3C);

        // R6 breakpoint while halted
        brk_pulse();
        chk("R6 irq", {31'b0, irq}, 32'd0);
        axi_rd(12'h000, rv); chk("R6 ctrl", rv, 32'd0);

        // R3 set run
        axi_wr(12'h000, 32'h1, 4'h0);
        chk("R3 run pin", {31'b0, core_run}, 32'd1);
        axi_rd(12'h000, rv); chk("R3 ctrl", rv, 32'd1);

        // R10 general window while running
        axi_rd(12'h084, rv); chk("R10 read zero", rv, 32'd0);
        wr_before = core_wr_cnt;
        axi_wr(12'h084, 32'h0BAD_0BAD, 4'hF);
        axi_wr(12'h080, 32'h0BAD_0BAD, 4'hF);
        chk("R10 no core write", core_wr_cnt - wr_before, 32'd0);
        axi_rd(12'h100, rv); chk("R11 cop0 while running", rv, 32'hCAFE_0000);

        // R4/R5 breakpoint while running
        @(negedge clk); core_brk = 1;
        @(negedge clk); core_brk = 0;
        chk("R4 run cleared", {31'b0, core_run}, 32'd0);
        chk("R5 irq high", {31'b0, irq}, 32'd1);
        @(negedge clk);
        chk("R5 irq one cycle", {31'b0, irq}, 32'd0);
        axi_rd(12'h000, rv); chk("R4 ctrl", rv, 32'd2);

        // R3 re-enable, pending kept
        axi_wr(12'h000, 32'h1, 4'hF);
        axi_rd(12'h000, rv); chk("R3 pend kept", rv, 32'd3);
        // R5 second break while pending: no pulse
        @(negedge clk); core_brk = 1;
        @(negedge clk); core_brk = 0;
        chk("R5 no irq when pending", {31'b0, irq}, 32'd0);
        chk("R4 run cleared again", {31'b0, core_run}, 32'd0);
        axi_rd(12'h000, rv); chk("R4 ctrl again", rv, 32'd2);

        // R3 write-one clears pending
        axi_wr(12'h000, 32'h2, 4'h0);
        axi_rd(12'h000, rv); chk("R3 w1c", rv, 32'd0);

        // R10 earlier ignored writes left registers intact
        axi_rd(12'h084, rv); chk("R10 gpr1 intact", rv, 32'h1111_2222);
        axi_rd(12'h080, rv); chk("R10 pc intact", rv, 32'h0000_1000);

        // R5 pulse again after clear
        axi_wr(12'h000, 32'h1, 4'hF);
        @(negedge clk); core_brk = 1;
        @(negedge clk); core_brk = 0;
        chk("R5 irq after clear", {31'b0, irq}, 32'd1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule